// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The block merges three active-low, asynchronous reset requests (power-on, hard and soft) into sequenced reset outputs for the rest of the chip. All timing is counted on one reference clock. Each request first passes a short synchroniser. A request is then accepted only if it stays low for a minimum number of reference edges, so glitches and runt pulses are dropped.

A power-on or hard request drives the hard, soft and internal core reset outputs. These outputs stay low for a fixed stretch after the request is withdrawn. A soft request drives only the soft output, and only for as long as it stays asserted. Requests are ranked power-on above hard above soft. A request of equal or higher rank that is accepted during a stretch restarts it. A lower-ranked request is dropped.

From the start of simulation the outputs are held low until the first power-on release and its stretch are complete. A two-bit code reports which source caused the most recent reset.

Top module: `reset_sequencer`

## Requirements
- R1: From time zero until the power-on input has been released, all three outputs are low and `cause_o` reads 3. After a release of the power-on input driven just after a falling clock edge, `hard_rst_no` and `soft_rst_no` stay low for EXT_LEN+2 more falling-edge samples.
- R2: A hard or soft request that is low across fewer than MIN_W rising reference edges is ignored and no output falls. A request that is low across exactly MIN_W rising edges is accepted.
- R3: After an accepted hard request is withdrawn, the hard, soft and core outputs stay low for EXT_LEN cycles once the release has passed the synchroniser. For a request held long enough to be accepted before it is withdrawn, this is EXT_LEN+2 falling-edge samples after the raw release.
- R4: An accepted soft request drives only `soft_rst_no` low. That output rises SYNC_N cycles after the raw request is released, with no stretch. `hard_rst_no` and `core_rst_no` stay high.
- R5: A higher-ranked request preempts a lower one in progress (power-on over hard over soft). A lower-ranked request accepted during a higher-ranked reset is ignored: it does not change `cause_o` or the release time of any output.
- R6: A hard request accepted during a hard stretch restarts the full EXT_LEN stretch from its own release.
- R7: After power-up, a later power-on request uses the same MIN_W width rule and the same EXT_LEN stretch as a hard request.
- R8: `cause_o` encodes the last accepted source as 1 for soft, 2 for hard and 3 for power-on. It keeps that value after the outputs are released.
- R9: `core_rst_no` falls together with `hard_rst_no` and rises one cycle after it.
- R10: Whenever `hard_rst_no` is low, `soft_rst_no` is also low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; all widths and stretches are counted on it |
| por_ni | input | 1 | Raw power-on reset request, active low, asynchronous |
| hard_ni | input | 1 | Raw hard reset request, active low, asynchronous |
| soft_ni | input | 1 | Raw soft reset request, active low, asynchronous |
| hard_rst_no | output | 1 | Sequenced hard reset, active low |
| soft_rst_no | output | 1 | Sequenced soft reset, active low |
| core_rst_no | output | 1 | Internal core reset, active low, released one cycle after hard |
| cause_o | output | 2 | Source of the most recent reset: 1 soft, 2 hard, 3 power-on |

## Verification
The bench builds the block with its default parameters: EXT_LEN of 4096, MIN_W of 4 and SYNC_N of 2. Every stretch is therefore counted to the exact cycle at its real length. Pulses of 3 and 4 edges sit on either side of the width threshold, so an off-by-one error in the qualifier shows up in either direction. The overlapping-request scenarios place a second request inside holds and inside a stretch already in progress. This reaches the preemption, the restart and the dropped-request paths of the controller.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;
  // value doubles as priority rank and as cause code
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SOFT = 2'd1,
    SRC_HARD = 2'd2,
    SRC_POR  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    ST_COLD,
    ST_IDLE,
    ST_HOLD,
    ST_EXT,
    ST_SOFT
  } seq_state_e;

  localparam int unsigned NUM_SRC = 3;  // lane 0 soft, 1 hard, 2 power-on
endpackage

// File: rtl/rst_sync_cell.sv
`timescale 1ns/1ps
module rst_sync_cell #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic raw_ni,
  output logic lo_o
);
  logic [SYNC_N-1:0] ff_q = '0;

  // assertion clears asynchronously, release walks through SYNC_N flops
  always_ff @(posedge clk_i or negedge raw_ni) begin
    if (!raw_ni) ff_q <= '0;
    else         ff_q <= {ff_q[SYNC_N-2:0], 1'b1};
  end

  assign lo_o = ~ff_q[SYNC_N-1];
endmodule

// File: rtl/rst_width_qual.sv
`timescale 1ns/1ps
module rst_width_qual #(
  parameter int unsigned MIN_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic lo_i,
  output logic evt_o
);
  // synchronised low lasts SYNC_N edges longer than the raw pulse
  localparam int unsigned THR = MIN_W + SYNC_N - 1;
  localparam int unsigned W_W = $clog2(THR + 2);

  logic [W_W-1:0] wcnt_q = '0;

  always_ff @(posedge clk_i) begin
    if (!lo_i)                       wcnt_q <= '0;
    else if (wcnt_q != W_W'(THR + 1)) wcnt_q <= wcnt_q + 1'b1;
  end

  assign evt_o = lo_i && (wcnt_q == W_W'(THR));

  a_r2_single_evt: assert property (@(posedge clk_i) disable iff (!lo_i)
    evt_o |=> !evt_o);
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned EXT_LEN = 4096
) (
  input  logic               clk_i,
  input  logic [NUM_SRC-1:0] lo_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               hard_act_o,
  output logic               soft_act_o,
  output src_e               src_o
);
  localparam int unsigned CNT_W = $clog2(EXT_LEN);

  seq_state_e       st_q  = ST_COLD;
  seq_state_e       st_d;
  src_e             src_q = SRC_POR;
  src_e             src_d;
  src_e             evt_src;
  src_e             cur_rank;
  logic [CNT_W-1:0] cnt_q = '0;
  logic [CNT_W-1:0] cnt_d;
  logic             take_evt;
  logic             src_lo;

  always_comb begin
    if      (evt_i[2]) evt_src = SRC_POR;
    else if (evt_i[1]) evt_src = SRC_HARD;
    else if (evt_i[0]) evt_src = SRC_SOFT;
    else               evt_src = SRC_NONE;
  end

  always_comb begin
    case (src_q)
      SRC_SOFT: src_lo = lo_i[0];
      SRC_HARD: src_lo = lo_i[1];
      SRC_POR:  src_lo = lo_i[2];
      default:  src_lo = 1'b0;
    endcase
  end

  assign cur_rank = (st_q == ST_IDLE) ? SRC_NONE : src_q;
  assign take_evt = (st_q != ST_COLD) && (evt_src != SRC_NONE) && (evt_src >= cur_rank);

  always_comb begin
    st_d  = st_q;
    src_d = src_q;
    cnt_d = cnt_q;
    if (st_q == ST_COLD) begin
      if (!lo_i[2]) begin
        st_d  = ST_EXT;
        cnt_d = CNT_W'(EXT_LEN - 1);
      end
    end else if (take_evt) begin
      st_d  = (evt_src == SRC_SOFT) ? ST_SOFT : ST_HOLD;
      src_d = evt_src;
    end else begin
      case (st_q)
        ST_HOLD: if (!src_lo) begin
          st_d  = ST_EXT;
          cnt_d = CNT_W'(EXT_LEN - 1);
        end
        ST_SOFT: if (!lo_i[0]) st_d = ST_IDLE;
        ST_EXT: begin
          if (cnt_q == '0) st_d = ST_IDLE;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    st_q  <= st_d;
    src_q <= src_d;
    cnt_q <= cnt_d;
  end

  assign hard_act_o = (st_q == ST_COLD) || (st_q == ST_HOLD) || (st_q == ST_EXT);
  assign soft_act_o = hard_act_o || (st_q == ST_SOFT);
  assign src_o      = src_q;

  a_r3_ext_count: assert property (@(posedge clk_i) disable iff (st_q == ST_COLD)
    (st_q == ST_EXT && cnt_q != '0 && !take_evt) |=> (st_q == ST_EXT && cnt_q == $past(cnt_q) - 1'b1));
  a_r3_ext_src: assert property (@(posedge clk_i) disable iff (st_q == ST_COLD)
    (st_q == ST_EXT) |-> (src_q == SRC_HARD || src_q == SRC_POR));
  a_r5_no_demote: assert property (@(posedge clk_i) disable iff (st_q == ST_COLD)
    (st_q == ST_HOLD || st_q == ST_EXT || st_q == ST_SOFT) |=> (src_q >= $past(src_q)));
endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned EXT_LEN = 4096,
  parameter int unsigned MIN_W   = 4,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       hard_ni,
  input  logic       soft_ni,
  output logic       hard_rst_no,
  output logic       soft_rst_no,
  output logic       core_rst_no,
  output logic [1:0] cause_o
);
  logic [NUM_SRC-1:0] raw_n;
  logic [NUM_SRC-1:0] lo;
  logic [NUM_SRC-1:0] evt;
  logic               hard_act;
  logic               soft_act;
  logic               core_lag_q = 1'b1;
  src_e               src;

  assign raw_n = {por_ni, hard_ni, soft_ni};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    rst_sync_cell #(.SYNC_N(SYNC_N)) i_sync (
      .clk_i  (clk_i),
      .raw_ni (raw_n[g]),
      .lo_o   (lo[g])
    );
    rst_width_qual #(.MIN_W(MIN_W), .SYNC_N(SYNC_N)) i_qual (
      .clk_i (clk_i),
      .lo_i  (lo[g]),
      .evt_o (evt[g])
    );
  end

  rst_seq_ctrl #(.EXT_LEN(EXT_LEN)) i_ctrl (
    .clk_i      (clk_i),
    .lo_i       (lo),
    .evt_i      (evt),
    .hard_act_o (hard_act),
    .soft_act_o (soft_act),
    .src_o      (src)
  );

  // core reset asserts with hard, releases one cycle later
  always_ff @(posedge clk_i) core_lag_q <= hard_act;

  assign hard_rst_no = ~hard_act;
  assign soft_rst_no = ~soft_act;
  assign core_rst_no = ~(hard_act | core_lag_q);
  assign cause_o     = src;

  a_r10_hard_soft: assert property (@(posedge clk_i) disable iff (!por_ni)
    !hard_rst_no |-> !soft_rst_no);
  a_r9_core_with_hard: assert property (@(posedge clk_i) disable iff (!por_ni)
    !hard_rst_no |-> !core_rst_no);
  a_r9_core_lag: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(hard_rst_no) |-> !core_rst_no);
endmodule

// File: tb/test_reset_sequencer.sv
`timescale 1ns/1ps
module test_reset_sequencer;
  localparam int EXT_LEN = 4096;
  localparam int MIN_W   = 4;
  localparam int SYNC_N  = 2;
  localparam int WIN     = EXT_LEN + 40;

  logic       clk_i   = 1'b0;
  logic       por_ni  = 1'b0;
  logic       hard_ni = 1'b1;
  logic       soft_ni = 1'b1;
  logic       hard_rst_no, soft_rst_no, core_rst_no;
  logic [1:0] cause_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  reset_sequencer #(.EXT_LEN(EXT_LEN), .MIN_W(MIN_W), .SYNC_N(SYNC_N)) i_reset_sequencer (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .hard_ni     (hard_ni),
    .soft_ni     (soft_ni),
    .hard_rst_no (hard_rst_no),
    .soft_rst_no (soft_rst_no),
    .core_rst_no (core_rst_no),
    .cause_o     (cause_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(int ch, logic v);
    case (ch)
      0: soft_ni = v;
      1: hard_ni = v;
      default: por_ni = v;
    endcase
  endtask

  task automatic pulse(int ch, int n);
    @(negedge clk_i); drive(ch, 1'b0);
    repeat (n) @(negedge clk_i);
    drive(ch, 1'b1);
  endtask

  task automatic measure(output int nh, output int ns, output int nc);
    nh = 0; ns = 0; nc = 0;
    repeat (WIN) begin
      @(negedge clk_i);
      if (!hard_rst_no) nh++;
      if (!soft_rst_no) ns++;
      if (!core_rst_no) nc++;
    end
  endtask

  task automatic never_low(string req, int n);
    int cnt = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (!hard_rst_no || !soft_rst_no || !core_rst_no) cnt++;
    end
    chk(req, "outputs low after runt pulse", cnt, 0);
  endtask

  task automatic t_cold();
    int nh, ns, nc;
    repeat (3) @(negedge clk_i);
    chk("R1", "hard at start", int'(hard_rst_no), 0);
    chk("R1", "soft at start", int'(soft_rst_no), 0);
    chk("R1", "core at start", int'(core_rst_no), 0);
    chk("R8", "cause at start", int'(cause_o), 3);
    repeat (5) @(negedge clk_i);
    por_ni = 1'b1;
    measure(nh, ns, nc);
    chk("R1", "hard stretch after power-on", nh, EXT_LEN + 2);
    chk("R1", "soft stretch after power-on", ns, EXT_LEN + 2);
    chk("R9", "core stretch after power-on", nc, EXT_LEN + 3);
  endtask

  task automatic t_runt();
    pulse(1, MIN_W - 1); never_low("R2", 12);
    pulse(0, MIN_W - 1); never_low("R2", 12);
    pulse(2, MIN_W - 1); never_low("R7", 12);
    chk("R2", "cause after runts", int'(cause_o), 3);
  endtask

  task automatic t_hard_min();
    int nh, ns, nc;
    pulse(1, MIN_W);
    measure(nh, ns, nc);
    chk("R2", "hard accepted at min width", nh, EXT_LEN + 1);
    chk("R9", "core at min width", nc, EXT_LEN + 2);
    chk("R8", "cause hard", int'(cause_o), 2);
  endtask

  task automatic t_hard_long();
    int nh, ns, nc;
    pulse(1, 20);
    measure(nh, ns, nc);
    chk("R3", "hard stretch", nh, EXT_LEN + 2);
    chk("R3", "soft stretch on hard", ns, EXT_LEN + 2);
    chk("R9", "core stretch on hard", nc, EXT_LEN + 3);
  endtask

  task automatic t_soft();
    int nh, ns, nc;
    pulse(0, 10);
    measure(nh, ns, nc);
    chk("R4", "soft release without stretch", ns, SYNC_N);
    chk("R4", "hard untouched by soft", nh, 0);
    chk("R4", "core untouched by soft", nc, 0);
    chk("R8", "cause soft", int'(cause_o), 1);
  endtask

  task automatic t_preempt_soft();
    int nh, ns, nc;
    @(negedge clk_i); soft_ni = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R5", "cause soft before preempt", int'(cause_o), 1);
    chk("R5", "hard high during soft", int'(hard_rst_no), 1);
    hard_ni = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R5", "cause after hard preempts", int'(cause_o), 2);
    chk("R5", "hard low after preempt", int'(hard_rst_no), 0);
    soft_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R10", "soft held by hard", int'(soft_rst_no), 0);
    hard_ni = 1'b1;
    measure(nh, ns, nc);
    chk("R5", "hard stretch after preempt", nh, EXT_LEN + 2);
    chk("R5", "soft follows hard", ns, EXT_LEN + 2);
  endtask

  task automatic t_lower_ignored();
    int nh, ns, nc;
    pulse(1, 20);
    repeat (100) @(negedge clk_i);
    pulse(0, 10);
    chk("R5", "cause kept during lower request", int'(cause_o), 2);
    measure(nh, ns, nc);
    chk("R5", "soft released with hard", ns, nh);
    chk("R5", "cause after ignored soft", int'(cause_o), 2);
  endtask

  task automatic t_restart();
    int nh, ns, nc;
    pulse(1, 20);
    repeat (1000) @(negedge clk_i);
    pulse(1, 20);
    measure(nh, ns, nc);
    chk("R6", "restarted stretch", nh, EXT_LEN + 2);
  endtask

  task automatic t_por_later();
    int nh, ns, nc;
    pulse(2, 10);
    measure(nh, ns, nc);
    chk("R7", "later power-on stretch", nh, EXT_LEN + 2);
    chk("R7", "cause power-on", int'(cause_o), 3);
    @(negedge clk_i); hard_ni = 1'b0;
    repeat (10) @(negedge clk_i);
    por_ni = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R5", "power-on preempts hard", int'(cause_o), 3);
    hard_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    por_ni = 1'b1;
    measure(nh, ns, nc);
    chk("R5", "stretch from power-on release", nh, EXT_LEN + 2);
    chk("R9", "core after power-on preempt", nc, EXT_LEN + 3);
  endtask

  initial begin
    t_cold();
    t_runt();
    t_hard_min();
    t_hard_long();
    t_soft();
    t_preempt_soft();
    t_lower_ignored();
    t_restart();
    t_por_later();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule